// File: doc/BRIEF.md
# Configurable Pin Input Capture Array

This block sits between a row of external pins and the input bus of an on-chip logic array. Each pin passes through its own capture cell. A cell can forward the pin straight through, act as a transparent latch, or act as an edge-triggered register. In the two storing modes, a per-cell select chooses the timing signal. The choice is either the shared bus address strobe or that cell's own product term from the logic array. The cell outputs drive the logic input bus.

Configuration is held in small word-wide registers on a simple write/read register port. The same port also returns the current cell outputs. This lets the microcontroller see exactly what the logic array sees.

All timing is relative to the system clock. The strobe is sampled each clock, and a rising edge is taken as a clock where it is high after being low on the previous clock. Latch transparency is combinational while the selected strobe is high. Reset puts every cell in pass-through mode, selects the address strobe for every cell and clears every stored value.

Top module: `input_capture_array`

## Requirements
- R1: While reset is high and after it is released, the mode field and the select field read as zero, every cell is in pass-through mode, and every stored value is zero. A stored value from before reset never reaches an output after reset.
- R2: In pass-through mode a cell output equals its pin in the same cycle, and nothing is stored.
- R3: Each cell has a 2-bit mode. Cell i uses bits [2i+1:2i] of the concatenated mode field. The codes are 00 pass-through, 01 latch and 10 register. Code 11 behaves exactly as pass-through.
- R4: In latch mode the output equals the pin while the selected strobe is high. While the strobe is low, the output holds the pin value sampled at the last clock edge at which the strobe was high.
- R5: In register mode the cell stores its pin at a clock edge where the selected strobe is high and was low at the previous edge. The new value appears after that edge. Pin changes at any other time do not alter the output.
- R6: Bit i of the select field times cell i: 0 selects the shared address strobe and 1 selects product term i. The unselected source has no effect on that cell.
- R7: The register port maps the mode field to addresses 0 and 1 (cells 0-3 at address 0, cell 0 in the low bits), the select field to address 2, and the live cell outputs to address 3. Reads are combinational from the address, and configuration writes read back unchanged.
- R8: Writes to the cell-output address or to any unmapped address (4 and above) change no configuration. Unmapped addresses read as zero.
- R9: Changing a cell's mode keeps its stored value. A cell moved from register mode to latch mode with its strobe low presents the value it captured earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NCELL | External pin values, one per cell |
| as_strobe_i | input | 1 | Shared bus address strobe |
| pterm_i | input | NCELL | Per-cell product term from the logic array |
| addr_i | input | AW | Register port address for reads and writes |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | DW | Register write data |
| rd_data_o | output | DW | Register read data, combinational from addr_i |
| cell_out_o | output | NCELL | Cell outputs onto the logic input bus |

## Verification
The bench uses the defaults: eight cells, an eight-bit data word and a four-bit address. With these values the 16-bit mode field spans two register words, so the split layout and the bit position of each cell are checked. The four-bit address also leaves twelve unmapped addresses, which are used to check that stray writes are ignored. A single configuration mixes all four mode codes with both timing sources across the eight cells. In that configuration, one stimulus sequence shows latches, registers and pass-through cells reacting differently to the same strobe, and cells on the other source ignoring it.

// File: rtl/icap_pkg.sv
`timescale 1ns/1ps
package icap_pkg;

    typedef enum logic [1:0] {
        CM_PASS  = 2'b00,
        CM_LATCH = 2'b01,
        CM_REG   = 2'b10,
        CM_RSVD  = 2'b11
    } cap_mode_e;

    typedef enum logic {
        SRC_ADDR_STROBE = 1'b0,
        SRC_PTERM       = 1'b1
    } cap_src_e;

    typedef struct packed {
        cap_mode_e mode;
        cap_src_e  src;
    } cell_cfg_t;

    // Reserved code folds onto pass-through
    function automatic cap_mode_e eff_mode(input logic [1:0] raw);
        case (raw)
            2'b01:   return CM_LATCH;
            2'b10:   return CM_REG;
            default: return CM_PASS;
        endcase
    endfunction

    function automatic int words_for(input int bits, input int dw);
        return (bits + dw - 1) / dw;
    endfunction

endpackage

// File: rtl/icap_edge.sv
`timescale 1ns/1ps
module icap_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/icap_cell.sv
`timescale 1ns/1ps
module icap_cell
    import icap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cfg_t cfg_i,
    input  logic      as_strobe_i,
    input  logic      pterm_i,
    input  logic      pin_i,
    output logic      out_o
);
    logic      strb;
    logic      rise;
    logic      held_q;
    cap_mode_e mode;

    assign strb = (cfg_i.src == SRC_PTERM) ? pterm_i : as_strobe_i;
    assign mode = eff_mode(cfg_i.mode);

    icap_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (strb),
        .rise_o (rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else begin
            case (mode)
                CM_LATCH: if (strb) held_q <= pin_i;
                CM_REG:   if (rise) held_q <= pin_i;
                default:  held_q <= held_q;
            endcase
        end
    end

    always_comb begin
        case (mode)
            CM_LATCH: out_o = strb ? pin_i : held_q;
            CM_REG:   out_o = held_q;
            default:  out_o = pin_i;
        endcase
    end
endmodule

// File: rtl/icap_regs.sv
`timescale 1ns/1ps
module icap_regs
    import icap_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      addr_i,
    input  logic               wr_en_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic [NCELL-1:0]   cell_out_i,
    output logic [DW-1:0]      rd_data_o,
    output logic [2*NCELL-1:0] mode_o,
    output logic [NCELL-1:0]   src_o
);
    localparam int MODE_W   = 2 * NCELL;
    localparam int N_MODE   = words_for(MODE_W, DW);
    localparam int N_SRC    = words_for(NCELL, DW);
    localparam int BASE_SRC = N_MODE;
    localparam int BASE_OUT = N_MODE + N_SRC;
    localparam int MODE_PW  = N_MODE * DW;
    localparam int SRC_PW   = N_SRC * DW;
    localparam logic [MODE_PW-1:0] MODE_MASK = {MODE_PW{1'b1}} >> (MODE_PW - MODE_W);
    localparam logic [SRC_PW-1:0]  SRC_MASK  = {SRC_PW{1'b1}}  >> (SRC_PW - NCELL);

    logic [MODE_PW-1:0] mode_pad_q;
    logic [SRC_PW-1:0]  src_pad_q;
    logic [SRC_PW-1:0]  out_pad;

    for (genvar r = 0; r < N_MODE; r++) begin : g_mode_word
        always_ff @(posedge clk) begin
            if (rst)
                mode_pad_q[r*DW +: DW] <= '0;
            else if (wr_en_i && addr_i == AW'(r))
                mode_pad_q[r*DW +: DW] <= wr_data_i & MODE_MASK[r*DW +: DW];
        end
    end

    for (genvar r = 0; r < N_SRC; r++) begin : g_src_word
        always_ff @(posedge clk) begin
            if (rst)
                src_pad_q[r*DW +: DW] <= '0;
            else if (wr_en_i && addr_i == AW'(BASE_SRC + r))
                src_pad_q[r*DW +: DW] <= wr_data_i & SRC_MASK[r*DW +: DW];
        end
    end

    always_comb begin
        out_pad              = '0;
        out_pad[NCELL-1:0]   = cell_out_i;
    end

    always_comb begin
        rd_data_o = '0;
        for (int r = 0; r < N_MODE; r++)
            if (addr_i == AW'(r)) rd_data_o = mode_pad_q[r*DW +: DW];
        for (int r = 0; r < N_SRC; r++) begin
            if (addr_i == AW'(BASE_SRC + r)) rd_data_o = src_pad_q[r*DW +: DW];
            if (addr_i == AW'(BASE_OUT + r)) rd_data_o = out_pad[r*DW +: DW];
        end
    end

    assign mode_o = mode_pad_q[MODE_W-1:0];
    assign src_o  = src_pad_q[NCELL-1:0];
endmodule

// File: rtl/input_capture_array.sv
`timescale 1ns/1ps
module input_capture_array
    import icap_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCELL-1:0] pin_i,
    input  logic             as_strobe_i,
    input  logic [NCELL-1:0] pterm_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [DW-1:0]    rd_data_o,
    output logic [NCELL-1:0] cell_out_o
);
    logic [2*NCELL-1:0] mode_cfg;
    logic [NCELL-1:0]   src_cfg;

    icap_regs #(.NCELL(NCELL), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .cell_out_i (cell_out_o),
        .rd_data_o  (rd_data_o),
        .mode_o     (mode_cfg),
        .src_o      (src_cfg)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cell_cfg_t cfg;
        assign cfg.mode = cap_mode_e'(mode_cfg[2*i +: 2]);
        assign cfg.src  = cap_src_e'(src_cfg[i]);

        icap_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .cfg_i       (cfg),
            .as_strobe_i (as_strobe_i),
            .pterm_i     (pterm_i[i]),
            .pin_i       (pin_i[i]),
            .out_o       (cell_out_o[i])
        );
    end
endmodule

// File: rtl/icap_checker.sv
`timescale 1ns/1ps
module icap_checker
    import icap_pkg::*;
#(
    parameter int NCELL = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en_i,
    input logic               as_strobe_i,
    input logic [NCELL-1:0]   pin_i,
    input logic [NCELL-1:0]   pterm_i,
    input logic [NCELL-1:0]   cell_out_o,
    input logic [2*NCELL-1:0] mode_cfg,
    input logic [NCELL-1:0]   src_cfg
);
    for (genvar i = 0; i < NCELL; i++) begin : g_chk
        logic      strb_c;
        cap_mode_e m_c;
        assign strb_c = src_cfg[i] ? pterm_i[i] : as_strobe_i;
        assign m_c    = eff_mode(mode_cfg[2*i +: 2]);

        // R2 and R3: pass-through and reserved code forward the pin
        a_r2_pass_forward: assert property (@(posedge clk) disable iff (rst)
            (m_c == CM_PASS) |-> (cell_out_o[i] == pin_i[i]));

        // R4: transparency while the selected strobe is high
        a_r4_latch_follow: assert property (@(posedge clk) disable iff (rst)
            (m_c == CM_LATCH && strb_c) |-> (cell_out_o[i] == pin_i[i]));

        // R4: hold while the selected strobe stays low
        a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
            (m_c == CM_LATCH && !strb_c && !wr_en_i) |=> (strb_c || $stable(cell_out_o[i])));

        // R5 and R6: capture on a rising edge of the selected source
        a_r5_reg_capture: assert property (@(posedge clk) disable iff (rst)
            (m_c == CM_REG && $rose(strb_c) && !wr_en_i) |=> (cell_out_o[i] == $past(pin_i[i])));

        // R5: no change without a rising edge
        a_r5_reg_hold: assert property (@(posedge clk) disable iff (rst)
            (m_c == CM_REG && !$rose(strb_c) && !wr_en_i && !$past(rst)) |=> $stable(cell_out_o[i]));
    end
endmodule

bind input_capture_array icap_checker #(.NCELL(NCELL)) u_icap_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .as_strobe_i (as_strobe_i),
    .pin_i       (pin_i),
    .pterm_i     (pterm_i),
    .cell_out_o  (cell_out_o),
    .mode_cfg    (mode_cfg),
    .src_cfg     (src_cfg)
);

// File: tb/tb_input_capture_array.sv
`timescale 1ns/1ps
module tb_input_capture_array;
    localparam int NCELL = 8;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCELL-1:0] pin_i = '0;
    logic             as_strobe_i = 1'b0;
    logic [NCELL-1:0] pterm_i = '0;
    logic [AW-1:0]    addr_i = '0;
    logic             wr_en_i = 1'b0;
    logic [DW-1:0]    wr_data_i = '0;
    logic [DW-1:0]    rd_data_o;
    logic [NCELL-1:0] cell_out_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    input_capture_array #(.NCELL(NCELL), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .as_strobe_i(as_strobe_i),
        .pterm_i(pterm_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .cell_out_o(cell_out_o)
    );

    // Config: c0 pass, c1 latch/AS, c2 reg/AS, c3 reserved,
    //         c4 latch/PT, c5 reg/PT, c6 pass, c7 reg/AS
    localparam logic [7:0] CFG_M0  = 8'hE4;
    localparam logic [7:0] CFG_M1  = 8'h89;
    localparam logic [7:0] CFG_SRC = 8'h30;

    typedef struct packed {
        logic [7:0] pin;
        logic       as;
        logic [7:0] pt;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{8'hFF, 1'b0, 8'h00, 8'h49},
        '{8'hFF, 1'b1, 8'h00, 8'h4B},
        '{8'h00, 1'b1, 8'h00, 8'h84},
        '{8'hFF, 1'b0, 8'h00, 8'hCD},
        '{8'h30, 1'b0, 8'h30, 8'h94},
        '{8'h00, 1'b1, 8'h00, 8'hB4},
        '{8'hFF, 1'b0, 8'h00, 8'h79}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        addr_i = a;
        #1;
        chk(req, rd_data_o, exp);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 pass-through after reset
        rd_chk(4'd0, 8'h00, "R1 mode word 0");
        rd_chk(4'd1, 8'h00, "R1 mode word 1");
        rd_chk(4'd2, 8'h00, "R1 select word");
        pin_i = 8'hA5;
        #1;
        chk("R1/R2 pass after reset", cell_out_o, 8'hA5);
        pin_i = 8'h00;

        // R7 configuration readback
        wr(4'd0, CFG_M0);
        wr(4'd1, CFG_M1);
        wr(4'd2, CFG_SRC);
        rd_chk(4'd0, CFG_M0, "R7 mode word 0");
        rd_chk(4'd1, CFG_M1, "R7 mode word 1");
        rd_chk(4'd2, CFG_SRC, "R7 select word");

        // R8 ignored writes
        wr(4'd3, 8'hFF);
        rd_chk(4'd3, 8'h00, "R8 output word after write");
        rd_chk(4'd0, CFG_M0, "R8 mode word 0 after output write");
        wr(4'd5, 8'hFF);
        rd_chk(4'd5, 8'h00, "R8 unmapped reads zero");
        rd_chk(4'd1, CFG_M1, "R8 mode word 1 after stray write");
        rd_chk(4'd2, CFG_SRC, "R8 select word after stray write");

        // R2/R3/R4/R5/R6 vector walk
        addr_i = 4'd3;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            pin_i = VEC[k].pin; as_strobe_i = VEC[k].as; pterm_i = VEC[k].pt;
            #1;
            chk($sformatf("R2/R3/R4/R5/R6 vec %0d out", k), cell_out_o, VEC[k].exp);
            chk($sformatf("R7 vec %0d readback", k), rd_data_o, VEC[k].exp);
        end

        // R9: c5 register -> latch keeps captured 1 with PT low
        wr(4'd1, 8'h85);
        @(negedge clk);
        pin_i = 8'h00;
        #1;
        chk("R9 held value survives mode change", cell_out_o, 8'h30);

        // R3: upper cells all pass-through
        wr(4'd1, 8'h00);
        @(negedge clk);
        pin_i = 8'hC3;
        #1;
        chk("R3 upper cells pass, lower unchanged", cell_out_o, 8'hC1);

        // R1: reset clears stored values
        wr(4'd1, CFG_M1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_chk(4'd1, 8'h00, "R1 mode word cleared by reset");
        wr(4'd0, CFG_M0);
        wr(4'd1, CFG_M1);
        wr(4'd2, CFG_SRC);
        @(negedge clk);
        pin_i = 8'hFF; as_strobe_i = 1'b0; pterm_i = 8'h00;
        #1;
        chk("R1 stored values cleared", cell_out_o, 8'h49);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule